// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block sits between a CMOS image sensor with a parallel 8-bit raw output and an external asynchronous SRAM. The sensor frames its data with three signals: a vertical sync pulse at each frame boundary, a horizontal reference that is high during the valid part of a line, and a pixel clock whose rising edge qualifies each byte. All three, together with the data bus, are brought into the system clock domain through two-flop synchronisers. Edges are then detected on the synchronised copies.

Software pulses a start request to arm the controller. The controller then waits for the next rising edge of vertical sync, so that a capture always begins on a frame boundary and never stores part of a frame. From that edge on, every pixel-clock rising edge with horizontal reference high produces one SRAM write. The address starts at zero and steps by one. The capture ends after a full frame of bytes, or earlier if the next vertical sync arrives. A done flag then stays high until the next start request.

A geometry checker counts pixels per line and lines per frame during the capture and raises a sticky error flag if the frame does not have the configured shape. The sensor stream cannot be stalled, so the pixel input has no ready signal and there is no back-pressure. The pixel clock period must be at least eight system clocks, which leaves room for the four-cycle SRAM write and for the synchronisers. The SRAM side is a plain strobe interface.

Top module: `cam_frame_capture`

## Requirements
- R1: After reset, chip select and write enable are high (inactive), the address is zero, and the busy, done and error flags are low.
- R2: While the controller is neither armed nor capturing, sensor activity causes no SRAM access. Chip select stays high whenever the busy flag is low.
- R3: A start request arms the controller and raises busy. Bytes of the frame already in progress are not stored. Storing begins only after the first rising edge of vertical sync that follows arming.
- R4: During a capture, exactly one byte is stored for each pixel-clock rising edge that occurs while horizontal reference is high. Bytes seen while horizontal reference is low are not stored. Bytes are stored in arrival order.
- R5: The first byte of a capture goes to address 0, and each further byte goes to the previous address plus one.
- R6: Each write drives chip select low for a setup cycle, then write enable low for exactly one system clock, then a hold cycle. Address and data do not change while write enable is low.
- R7: Once LINE_PIX×FRAME_LINES bytes are stored, writing stops. Done goes high and busy goes low, and done holds until the next start request. Frames that arrive meanwhile are not stored.
- R8: A rising edge of vertical sync that arrives before the full byte count ends the capture. Done goes high and the error flag is set, because the frame has fewer lines than FRAME_LINES.
- R9: The error flag is set if any captured line has a pixel count other than LINE_PIX. It stays set until the next start request clears it.
- R10: A start request that arrives while armed or capturing is ignored. The running capture continues with its address sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_vsync | input | 1 | Sensor vertical sync, asynchronous; its rising edge marks a frame boundary |
| cam_href | input | 1 | Sensor horizontal reference, asynchronous; high while a line is valid |
| cam_pclk | input | 1 | Sensor pixel clock, sampled as data; its rising edge qualifies a byte |
| cam_data | input | DATA_W | Sensor raw pixel byte |
| start_req | input | 1 | One-cycle request to arm a capture |
| sram_addr | output | ADDR_W | SRAM byte address |
| sram_data | output | DATA_W | SRAM write data |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| capture_busy | output | 1 | High while armed or capturing |
| capture_done | output | 1 | High from the end of a capture until the next start request |
| frame_error | output | 1 | Sticky geometry error for the last capture |

## Verification
The bench builds the block with LINE_PIX = 8 and FRAME_LINES = 4, which gives a 32-byte frame and a 5-bit address. At this size every stored byte of every capture can be compared against a value the bench computes from the frame seed, the line number and the pixel number. Several frames are swept that way, including a capture armed in the middle of a frame. The small frame also places the boundary cases within a few hundred clocks: the full-count stop, a short line, an early vertical sync, address wrap after the last byte, and a start request during a capture.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_RUN   = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_t;

  typedef enum logic [1:0] {
    WR_IDLE   = 2'd0,
    WR_SETUP  = 2'd1,
    WR_STROBE = 2'd2,
    WR_HOLD   = 2'd3
  } wr_state_t;

endpackage

// File: rtl/cam_sync_in.sv
module cam_sync_in #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_raw,
  input  logic              href_raw,
  input  logic              pclk_raw,
  input  logic [DATA_W-1:0] data_raw,
  output logic              vs_rise,
  output logic              href_lvl,
  output logic              href_fall,
  output logic              pix_stb,
  output logic [DATA_W-1:0] pix_data
);

  // bus layout: {data, pclk, href, vsync}
  localparam int NB = DATA_W + 3;

  logic [NB-1:0] stg1, stg2;
  logic [2:0]    stg3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
      stg3 <= '0;
    end else begin
      stg1 <= {data_raw, pclk_raw, href_raw, vsync_raw};
      stg2 <= stg1;
      stg3 <= stg2[2:0];
    end
  end

  assign vs_rise   = stg2[0] & ~stg3[0];
  assign href_lvl  = stg2[1];
  assign href_fall = ~stg2[1] & stg3[1];
  assign pix_stb   = stg2[2] & ~stg3[2];
  assign pix_data  = stg2[NB-1:3];

endmodule

// File: rtl/cam_sram_wr.sv
module cam_sram_wr
  import cam_cap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 101376,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_clr,
  input  logic              req,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              full,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              cs_n,
  output logic              we_n
);

  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  wr_state_t st;

  assign busy = (st != WR_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= WR_IDLE;
      addr <= '0;
      data <= '0;
      cs_n <= 1'b1;
      we_n <= 1'b1;
      full <= 1'b0;
    end else begin
      full <= 1'b0;
      unique case (st)
        WR_IDLE: begin
          if (addr_clr) begin
            addr <= '0;
          end else if (req) begin
            data <= req_data;
            cs_n <= 1'b0;
            st   <= WR_SETUP;
          end
        end
        WR_SETUP: begin
          we_n <= 1'b0;
          st   <= WR_STROBE;
        end
        WR_STROBE: begin
          we_n <= 1'b1;
          st   <= WR_HOLD;
        end
        WR_HOLD: begin
          cs_n <= 1'b1;
          st   <= WR_IDLE;
          if (addr == ADDR_LAST) begin
            addr <= '0;
            full <= 1'b1;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        default: st <= WR_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cam_geom_chk.sv
module cam_geom_chk #(
  parameter int LINE_PIX    = 352,
  parameter int FRAME_LINES = 288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic pix,
  input  logic line_end,
  input  logic frame_cut,
  output logic err
);

  localparam int PW = $clog2(LINE_PIX + 1);
  localparam int LW = $clog2(FRAME_LINES + 1);
  localparam logic [PW-1:0] PIX_FULL  = PW'(LINE_PIX);
  localparam logic [LW-1:0] LINE_FULL = LW'(FRAME_LINES);

  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
      err      <= 1'b0;
    end else if (clr) begin
      pix_cnt  <= '0;
      line_cnt <= '0;
      err      <= 1'b0;
    end else if (active) begin
      if (pix) begin
        if (pix_cnt == PIX_FULL) err <= 1'b1;
        else                     pix_cnt <= pix_cnt + 1'b1;
      end
      if (line_end) begin
        if (pix_cnt != PIX_FULL) err <= 1'b1;
        pix_cnt <= '0;
        if (line_cnt != LINE_FULL) line_cnt <= line_cnt + 1'b1;
      end
      if (frame_cut && (line_cnt != LINE_FULL)) err <= 1'b1;
    end
  end

endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture
  import cam_cap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LINE_PIX    = 352,
  parameter int FRAME_LINES = 288,
  localparam int FRAME_BYTES = LINE_PIX * FRAME_LINES,
  localparam int ADDR_W      = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cam_vsync,
  input  logic              cam_href,
  input  logic              cam_pclk,
  input  logic [DATA_W-1:0] cam_data,
  input  logic              start_req,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_data,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              capture_busy,
  output logic              capture_done,
  output logic              frame_error
);

  logic              vs_rise, href_lvl, href_fall, pix_stb;
  logic [DATA_W-1:0] pix_data;
  logic              wr_busy, wr_full;
  logic              cut_pend;
  cap_state_t        st;

  cam_sync_in #(.DATA_W(DATA_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsync_raw (cam_vsync),
    .href_raw  (cam_href),
    .pclk_raw  (cam_pclk),
    .data_raw  (cam_data),
    .vs_rise   (vs_rise),
    .href_lvl  (href_lvl),
    .href_fall (href_fall),
    .pix_stb   (pix_stb),
    .pix_data  (pix_data)
  );

  logic arm, running, cut_now, take_pix, frame_cut;

  assign arm       = start_req && (st == CAP_IDLE || st == CAP_DONE);
  assign running   = (st == CAP_RUN);
  assign cut_now   = running && (cut_pend || vs_rise) && !wr_busy && !wr_full;
  assign take_pix  = running && pix_stb && href_lvl && !cut_pend && !vs_rise
                     && !wr_busy && !wr_full;
  assign frame_cut = cut_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CAP_IDLE;
      cut_pend <= 1'b0;
    end else begin
      unique case (st)
        CAP_IDLE, CAP_DONE: begin
          cut_pend <= 1'b0;
          if (arm) st <= CAP_ARMED;
        end
        CAP_ARMED: begin
          if (vs_rise) st <= CAP_RUN;
        end
        CAP_RUN: begin
          if (wr_full) begin
            st       <= CAP_DONE;
            cut_pend <= 1'b0;
          end else if (cut_now) begin
            st       <= CAP_DONE;
            cut_pend <= 1'b0;
          end else if (vs_rise) begin
            cut_pend <= 1'b1;
          end
        end
        default: st <= CAP_IDLE;
      endcase
    end
  end

  cam_sram_wr #(
    .DATA_W (DATA_W),
    .DEPTH  (FRAME_BYTES),
    .ADDR_W (ADDR_W)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_clr (arm),
    .req      (take_pix),
    .req_data (pix_data),
    .busy     (wr_busy),
    .full     (wr_full),
    .addr     (sram_addr),
    .data     (sram_data),
    .cs_n     (sram_cs_n),
    .we_n     (sram_we_n)
  );

  cam_geom_chk #(
    .LINE_PIX    (LINE_PIX),
    .FRAME_LINES (FRAME_LINES)
  ) u_geom (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (arm),
    .active    (running),
    .pix       (take_pix),
    .line_end  (href_fall),
    .frame_cut (frame_cut),
    .err       (frame_error)
  );

  assign capture_busy = (st == CAP_ARMED) || (st == CAP_RUN);
  assign capture_done = (st == CAP_DONE);

endmodule

// File: rtl/cam_frame_capture_chk.sv
module cam_frame_capture_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_data,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              capture_busy,
  input logic              capture_done,
  input logic              start_req
);

  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n); // R6

  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n); // R6

  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> ($stable(sram_addr) && $stable(sram_data))); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |-> ((sram_addr == $past(sram_addr) + 1'b1) || (sram_addr == '0))); // R5

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_busy |-> sram_cs_n); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_done && !start_req) |=> capture_done); // R7

endmodule

bind cam_frame_capture cam_frame_capture_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sram_addr    (sram_addr),
  .sram_data    (sram_data),
  .sram_cs_n    (sram_cs_n),
  .sram_we_n    (sram_we_n),
  .capture_busy (capture_busy),
  .capture_done (capture_done),
  .start_req    (start_req)
);

// File: tb/test_cam_frame_capture.sv
module test_cam_frame_capture;

  localparam int LP  = 8;
  localparam int FL  = 4;
  localparam int TOT = LP * FL;
  localparam int AW  = $clog2(TOT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cam_vsync = 1'b0, cam_href = 1'b0, cam_pclk = 1'b0;
  logic [7:0]    cam_data = 8'h00;
  logic          start_req = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_data;
  logic          sram_cs_n, sram_we_n, capture_busy, capture_done, frame_error;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cam_frame_capture #(.DATA_W(8), .LINE_PIX(LP), .FRAME_LINES(FL)) i_cam_frame_capture (
    .clk(clk), .rst_n(rst_n), .cam_vsync(cam_vsync), .cam_href(cam_href),
    .cam_pclk(cam_pclk), .cam_data(cam_data), .start_req(start_req),
    .sram_addr(sram_addr), .sram_data(sram_data), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .capture_busy(capture_busy),
    .capture_done(capture_done), .frame_error(frame_error)
  );

  // SRAM model and strobe monitor, sampled at the falling edge
  logic [7:0]    mem [TOT];
  int            wr_cnt = 0;
  int            bad_pulse = 0;
  int            bad_order = 0;
  logic          prev_we_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic [7:0]    prev_data = '0;
  int            exp_addr = 0;

  always @(negedge clk) begin
    if (!sram_we_n) begin
      if (!prev_we_n || sram_cs_n) bad_pulse++;
      if (sram_addr != prev_addr || sram_data != prev_data) bad_pulse++;
      if (int'(sram_addr) != exp_addr) bad_order++;
      mem[sram_addr] = sram_data;
      wr_cnt++;
      exp_addr = (exp_addr + 1) % TOT;
    end
    prev_we_n = sram_we_n;
    prev_addr = sram_addr;
    prev_data = sram_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_val(input int seed, input int l, input int p);
    return 8'((seed * 41 + l * LP + p) & 255);
  endfunction

  task automatic pixel(input logic h, input logic [7:0] d);
    @(negedge clk);
    cam_href = h;
    cam_data = d;
    repeat (4) @(negedge clk);
    cam_pclk = 1'b1;
    repeat (4) @(negedge clk);
    cam_pclk = 1'b0;
  endtask

  task automatic vsync_pulse();
    @(negedge clk);
    cam_vsync = 1'b1;
    pixel(1'b0, 8'hEE);
    pixel(1'b0, 8'hEE);
    cam_vsync = 1'b0;
    pixel(1'b0, 8'hEE);
  endtask

  // short_line: index of a line sent with one pixel missing, -1 for none
  task automatic lines(input int first, input int n, input int seed, input int short_line);
    for (int l = first; l < first + n; l++) begin
      for (int p = 0; p < ((l == short_line) ? LP - 1 : LP); p++)
        pixel(1'b1, pix_val(seed, l, p));
      pixel(1'b0, 8'hEE);
      pixel(1'b0, 8'hEE);
    end
  endtask

  task automatic start();
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    exp_addr = 0;
  endtask

  task automatic check_frame(input int seed, input string req);
    for (int l = 0; l < FL; l++)
      for (int p = 0; p < LP; p++)
        check(mem[l * LP + p] == pix_val(seed, l, p), req,
              int'(mem[l * LP + p]), int'(pix_val(seed, l, p)));
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sram_cs_n && sram_we_n, "R1 strobes", {30'd0, sram_cs_n, sram_we_n}, 3);
    check(sram_addr == '0, "R1 addr", int'(sram_addr), 0);
    check(!capture_busy && !capture_done && !frame_error, "R1 flags",
          {29'd0, capture_busy, capture_done, frame_error}, 0);
    rst_n = 1'b1;

    // R2: a frame with no start request is ignored
    vsync_pulse();
    lines(0, FL, 7, -1);
    check(wr_cnt == 0, "R2 no writes while idle", wr_cnt, 0);
    check(!capture_busy && !capture_done, "R2 flags idle",
          {30'd0, capture_busy, capture_done}, 0);

    // R3: arm in mid-frame, partial frame not stored
    vsync_pulse();
    lines(0, 2, 9, -1);
    start();
    check(capture_busy, "R3 busy after arm", int'(capture_busy), 1);
    lines(2, 1, 9, -1);
    start();  // R10: request while armed is ignored
    lines(3, 1, 9, -1);
    check(wr_cnt == 0, "R3 partial frame not stored", wr_cnt, 0);

    // R4 R5 R6: full capture, with a request in the middle (R10)
    vsync_pulse();
    lines(0, 2, 1, -1);
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    lines(2, 2, 1, -1);
    check(wr_cnt == TOT, "R4 byte count", wr_cnt, TOT);
    check(capture_done && !capture_busy, "R7 done after full frame",
          {30'd0, capture_done, capture_busy}, 2);
    check(!frame_error, "R9 clean frame no error", int'(frame_error), 0);
    check(bad_order == 0, "R5 R10 address sequence", bad_order, 0);
    check(bad_pulse == 0, "R6 strobe shape", bad_pulse, 0);
    check_frame(1, "R4 stored data");

    // R7: later frames are not stored while done
    base = wr_cnt;
    vsync_pulse();
    lines(0, FL, 2, -1);
    check(wr_cnt == base, "R7 no writes while done", wr_cnt - base, 0);
    check(capture_done, "R7 done holds", int'(capture_done), 1);

    // R4 R5: sweep of several seeds, each a full capture
    for (int s = 3; s < 7; s++) begin
      base = wr_cnt;
      start();
      check(!capture_done && capture_busy, "R3 rearm clears done",
            {30'd0, capture_done, capture_busy}, 1);
      vsync_pulse();
      lines(0, FL, s, -1);
      check(wr_cnt - base == TOT, "R4 sweep count", wr_cnt - base, TOT);
      check(capture_done && !frame_error, "R7 sweep done",
            {30'd0, capture_done, frame_error}, 2);
      check_frame(s, "R4 sweep data");
    end

    // R9: a short line sets the error; capture still ends on full count
    base = wr_cnt;
    start();
    vsync_pulse();
    lines(0, FL + 1, 11, 1);
    check(wr_cnt - base == TOT, "R9 count with short line", wr_cnt - base, TOT);
    check(capture_done && frame_error, "R9 error on short line",
          {30'd0, capture_done, frame_error}, 3);
    start();
    check(!frame_error, "R9 error cleared by start", int'(frame_error), 0);

    // R8: early vertical sync cuts the frame
    base = wr_cnt;
    vsync_pulse();
    lines(0, 2, 12, -1);
    check(!capture_done, "R8 not done before cut", int'(capture_done), 0);
    vsync_pulse();
    check(wr_cnt - base == 2 * LP, "R8 bytes before cut", wr_cnt - base, 2 * LP);
    check(capture_done && frame_error, "R8 done and error after cut",
          {30'd0, capture_done, frame_error}, 3);
    check(bad_order == 0 && bad_pulse == 0, "R5 R6 final sequence",
          bad_order + bad_pulse, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule